// File: doc/BRIEF.md
# E1 Line Test and Loopback Steering

This block holds the digital steering between the system-side data pins and the line-side bipolar data of a 2.048 Mb/s E1 line interface. It picks what goes to the line (system data, received line data, or a generated all-ones pattern) and what goes to the receive outputs (line data, looped-back system data, or all ones). It also applies the selected pin polarity and the matching update edge, formats data as single-rail or dual-rail, and forces the alarm outputs while the alarm test input is held low.

Every timing source arrives as a one-cycle strobe in the block clock domain. `tclk_fall_i` marks a falling edge of the transmit clock. `rclk_rise_i` and `rclk_fall_i` mark the edges of the recovered receive clock. `mclk_tick_i` marks one bit period of the free-running 2.048 MHz master clock. An output register changes only on a block clock edge where the strobe selected for its path is high. In dual-rail mode, `ttip_o` and `tring_o` follow the two transmit rails as marks. In single-rail mode they carry the AMI-encoded data.

Top module: `e1_test_loop_ctl`

## Requirements
- R1: While `taos_i` is high, each `mclk_tick_i` puts one mark on the line outputs, and successive marks alternate. After reset the first mark is on `ttip_o` (`ttip_o`=1, `tring_o`=0). `tclk_fall_i` does not update the line outputs while `taos_i` is high.
- R2: When `taos_i` and `rlb_en_i` are both high, `rclk_rise_i` does not update the line outputs, and the all-ones marks continue on `mclk_tick_i`.
- R3: While `raos_i` is high, each `mclk_tick_i` updates the receive outputs with all ones. In single-rail mode `rpos_o`=1. In dual-rail mode the marks alternate between `rpos_o` and `rneg_o`, starting on `rpos_o` after reset. The selected output polarity is applied in both modes.
- R4: When `raos_i` and `dlb_en_i` are both high, `tclk_fall_i` does not update the receive outputs.
- R5: While `atm_n_i` is low, `clk_loss_o`=0, `rlos_o`=0 and `lcv_o`=1, and the data paths still move data as usual. While `atm_n_i` is high, the three alarm outputs equal `clk_loss_i`, `rlos_i` and `lcv_i`.
- R6: With `inv_sel_i` low, the transmit pins are active-high and are sampled on `tclk_fall_i`. The receive outputs are active-high and update from the line on `rclk_fall_i` only.
- R7: With `inv_sel_i` high in dual-rail mode, the transmit pins and the receive outputs are active-low, and the receive outputs update from the line on `rclk_rise_i` only. In single-rail mode `inv_sel_i` has no effect.
- R8: With `ja_en_i` low, `fmt_sel_i`=1 selects dual-rail mode and `fmt_sel_i`=0 selects single-rail mode.
- R9: With `ja_en_i` high, `fmt_sel_i` is ignored. A mark on `tneg_i` (the pin level XOR `inv_sel_i` equal to 1) sampled on `tclk_fall_i` selects dual-rail mode. The mode returns to single-rail on the 32nd consecutive `tclk_fall_i` with no such mark, and is still dual-rail after the 31st.
- R10: In single-rail mode, `tpos_i` is AMI-encoded onto the line and marks alternate between `ttip_o` and `tring_o`. `tneg_i` is not data. `rpos_o` carries the line mark (either rail), and `rneg_o` carries the alarm-test-adjusted code violation flag.
- R11: With `rlb_en_i` high and `taos_i` low, each `rclk_rise_i` copies `rline_pos_i` and `rline_neg_i` to `ttip_o` and `tring_o`, and `tclk_fall_i` does not update them.
- R12: With `dlb_en_i` high and `raos_i` low, the receive outputs take the transmit system data on `tclk_fall_i`, with the output polarity applied, and ignore the line strobes.
- R13: Reset clears `ttip_o`, `tring_o`, `rpos_o` and `rneg_o` to 0 and selects single-rail mode when `ja_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tclk_fall_i | input | 1 | Transmit clock falling-edge strobe |
| rclk_rise_i | input | 1 | Recovered clock rising-edge strobe |
| rclk_fall_i | input | 1 | Recovered clock falling-edge strobe |
| mclk_tick_i | input | 1 | Master clock bit-period strobe |
| taos_i | input | 1 | Send all ones toward the line |
| raos_i | input | 1 | Send all ones to the receive outputs |
| rlb_en_i | input | 1 | Remote loopback enable |
| dlb_en_i | input | 1 | Digital loopback enable |
| atm_n_i | input | 1 | Alarm test, active low |
| inv_sel_i | input | 1 | Inverted pin polarity select |
| fmt_sel_i | input | 1 | Dual-rail (1) or single-rail (0) when automatic detection is off |
| ja_en_i | input | 1 | Automatic format detection on the negative transmit rail |
| tpos_i | input | 1 | Transmit positive rail or single-rail data |
| tneg_i | input | 1 | Transmit negative rail or code select |
| rline_pos_i | input | 1 | Positive mark from the line receiver |
| rline_neg_i | input | 1 | Negative mark from the line receiver |
| lcv_i | input | 1 | Code violation flag from the decoder |
| clk_loss_i | input | 1 | Clock-loss alarm from recovery |
| rlos_i | input | 1 | Receive-loss alarm |
| ttip_o | output | 1 | Positive mark to the line driver |
| tring_o | output | 1 | Negative mark to the line driver |
| rpos_o | output | 1 | Receive positive rail or single-rail data |
| rneg_o | output | 1 | Receive negative rail or code violation |
| lcv_o | output | 1 | Code violation alarm |
| clk_loss_o | output | 1 | Clock-loss alarm |
| rlos_o | output | 1 | Receive-loss alarm |

## Verification
All-ones insertion and a loopback can both claim the same output register. The bench raises `taos_i` together with `rlb_en_i`, and `raos_i` together with `dlb_en_i`. It then fires the loopback strobe alone, which must leave the outputs unchanged, and then a master clock tick, which must produce the next alternating mark. The alarm test forcing and a line transfer also share cycles: a receive strobe with `atm_n_i` low must still move line data, while the three alarms read their forced values.

// File: rtl/e1tl_pkg.sv
package e1tl_pkg;

    typedef enum logic [1:0] {
        TX_ONES,
        TX_LOOP,
        TX_RAILS,
        TX_CODED
    } tx_src_e;

    typedef enum logic [1:0] {
        RX_ONES,
        RX_TXDATA,
        RX_LINE
    } rx_src_e;

    typedef struct packed {
        logic ttip;
        logic tring;
        logic rpos;
        logic rneg;
    } pins_t;

endpackage

// File: rtl/e1_ami_alt.sv
module e1_ami_alt (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic mark_i,
    output logic pos_o,
    output logic neg_o
);
    logic ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (step_i && mark_i) begin
            ph_d = ~ph_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign pos_o = mark_i & ~ph_q;
    assign neg_o = mark_i & ph_q;
endmodule

// File: rtl/e1_rail_activity.sv
module e1_rail_activity #(
    parameter int IDLE_WIN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic mark_i,
    output logic active_o
);
    localparam int CNT_W = (IDLE_WIN > 2) ? $clog2(IDLE_WIN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_WIN - 1);

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } act_t;

    act_t d, q;

    always_comb begin
        d = q;
        if (step_i) begin
            if (mark_i) begin
                d.act = 1'b1;
                d.cnt = '0;
            end else if (q.act) begin
                if (q.cnt == LAST) begin
                    d.act = 1'b0;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active_o = q.act;

    // R9: an idle detector holds no partial count
    p_idle_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !q.act |-> (q.cnt == '0));
endmodule

// File: rtl/e1_test_loop_ctl.sv
module e1_test_loop_ctl
    import e1tl_pkg::*;
#(
    parameter int IDLE_WIN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk_fall_i,
    input  logic rclk_rise_i,
    input  logic rclk_fall_i,
    input  logic mclk_tick_i,
    input  logic taos_i,
    input  logic raos_i,
    input  logic rlb_en_i,
    input  logic dlb_en_i,
    input  logic atm_n_i,
    input  logic inv_sel_i,
    input  logic fmt_sel_i,
    input  logic ja_en_i,
    input  logic tpos_i,
    input  logic tneg_i,
    input  logic rline_pos_i,
    input  logic rline_neg_i,
    input  logic lcv_i,
    input  logic clk_loss_i,
    input  logic rlos_i,
    output logic ttip_o,
    output logic tring_o,
    output logic rpos_o,
    output logic rneg_o,
    output logic lcv_o,
    output logic clk_loss_o,
    output logic rlos_o
);
    logic    act, dual, inv_eff, tp, tn, lcv_f;
    tx_src_e tx_src;
    rx_src_e rx_src;
    logic    tx_step, rx_step;
    logic    tx_ami_step, tx_ami_mark, tx_pos, tx_neg;
    logic    rx_ami_step, rx_pos, rx_neg;
    logic    vp, vn, vbit;
    pins_t   d, q;

    e1_rail_activity #(.IDLE_WIN(IDLE_WIN)) u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (tclk_fall_i),
        .mark_i   (tneg_i ^ inv_sel_i),
        .active_o (act)
    );

    // mode, polarity and alarm forcing
    always_comb begin
        dual    = ja_en_i ? act : fmt_sel_i;
        inv_eff = inv_sel_i & dual;
        tp      = tpos_i ^ inv_eff;
        tn      = tneg_i ^ inv_eff;
        lcv_f   = atm_n_i ? lcv_i : 1'b1;
    end

    assign lcv_o      = lcv_f;
    assign clk_loss_o = atm_n_i & clk_loss_i;
    assign rlos_o     = atm_n_i & rlos_i;

    // transmit source: all ones wins over remote loopback
    always_comb begin
        if (taos_i) begin
            tx_src = TX_ONES;
        end else if (rlb_en_i) begin
            tx_src = TX_LOOP;
        end else if (dual) begin
            tx_src = TX_RAILS;
        end else begin
            tx_src = TX_CODED;
        end
        unique case (tx_src)
            TX_ONES:  tx_step = mclk_tick_i;
            TX_LOOP:  tx_step = rclk_rise_i;
            default:  tx_step = tclk_fall_i;
        endcase
        tx_ami_step = tx_step && ((tx_src == TX_ONES) || (tx_src == TX_CODED));
        tx_ami_mark = (tx_src == TX_ONES) | tp;
    end

    // receive source: all ones wins over digital loopback
    always_comb begin
        if (raos_i) begin
            rx_src  = RX_ONES;
            rx_step = mclk_tick_i;
        end else if (dlb_en_i) begin
            rx_src  = RX_TXDATA;
            rx_step = tclk_fall_i;
        end else begin
            rx_src  = RX_LINE;
            rx_step = inv_eff ? rclk_rise_i : rclk_fall_i;
        end
        rx_ami_step = rx_step && (rx_src == RX_ONES) && dual;
    end

    e1_ami_alt u_tx_ami (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (tx_ami_step),
        .mark_i (tx_ami_mark),
        .pos_o  (tx_pos),
        .neg_o  (tx_neg)
    );

    e1_ami_alt u_rx_ami (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (rx_ami_step),
        .mark_i (1'b1),
        .pos_o  (rx_pos),
        .neg_o  (rx_neg)
    );

    // next values of the four data pins
    always_comb begin
        d = q;
        unique case (rx_src)
            RX_ONES: begin
                vp   = rx_pos;
                vn   = rx_neg;
                vbit = 1'b1;
            end
            RX_TXDATA: begin
                vp   = tp;
                vn   = tn;
                vbit = tp;
            end
            default: begin
                vp   = rline_pos_i;
                vn   = rline_neg_i;
                vbit = rline_pos_i | rline_neg_i;
            end
        endcase
        if (tx_step) begin
            unique case (tx_src)
                TX_LOOP: begin
                    d.ttip  = rline_pos_i;
                    d.tring = rline_neg_i;
                end
                TX_RAILS: begin
                    d.ttip  = tp;
                    d.tring = tn;
                end
                default: begin
                    d.ttip  = tx_pos;
                    d.tring = tx_neg;
                end
            endcase
        end
        if (rx_step) begin
            if (dual) begin
                d.rpos = vp ^ inv_eff;
                d.rneg = vn ^ inv_eff;
            end else begin
                d.rpos = vbit;
                d.rneg = lcv_f;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ttip_o  = q.ttip;
    assign tring_o = q.tring;
    assign rpos_o  = q.rpos;
    assign rneg_o  = q.rneg;

    p_ones_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (taos_i && mclk_tick_i) |=> (ttip_o != tring_o));

    p_ones_over_rloop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (taos_i && rlb_en_i && !mclk_tick_i) |=> $stable({ttip_o, tring_o}));

    p_ones_over_dloop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (raos_i && dlb_en_i && !mclk_tick_i) |=> $stable({rpos_o, rneg_o}));

    p_alarm_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !atm_n_i |-> (lcv_o && !clk_loss_o && !rlos_o));

    p_rx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tclk_fall_i && !rclk_rise_i && !rclk_fall_i && !mclk_tick_i)
        |=> $stable({rpos_o, rneg_o}));
endmodule

// File: tb/test_e1_test_loop_ctl.sv
module test_e1_test_loop_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tclk_fall = 0, rclk_rise = 0, rclk_fall = 0, mclk_tick = 0;
    logic taos = 0, raos = 0, rlb_en = 0, dlb_en = 0, atm_n = 1;
    logic inv_sel = 0, fmt_sel = 0, ja_en = 0;
    logic tpos = 0, tneg = 0, rline_pos = 0, rline_neg = 0;
    logic lcv = 0, clk_loss = 0, rlos = 0;
    logic ttip, tring, rpos, rneg, lcv_o, clk_loss_o, rlos_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    e1_test_loop_ctl i_e1_test_loop_ctl (
        .clk(clk), .rst_n(rst_n),
        .tclk_fall_i(tclk_fall), .rclk_rise_i(rclk_rise),
        .rclk_fall_i(rclk_fall), .mclk_tick_i(mclk_tick),
        .taos_i(taos), .raos_i(raos), .rlb_en_i(rlb_en), .dlb_en_i(dlb_en),
        .atm_n_i(atm_n), .inv_sel_i(inv_sel), .fmt_sel_i(fmt_sel),
        .ja_en_i(ja_en), .tpos_i(tpos), .tneg_i(tneg),
        .rline_pos_i(rline_pos), .rline_neg_i(rline_neg),
        .lcv_i(lcv), .clk_loss_i(clk_loss), .rlos_i(rlos),
        .ttip_o(ttip), .tring_o(tring), .rpos_o(rpos), .rneg_o(rneg),
        .lcv_o(lcv_o), .clk_loss_o(clk_loss_o), .rlos_o(rlos_o)
    );

    // strobe codes: 0 tclk fall, 1 rclk rise, 2 rclk fall, 3 mclk tick
    typedef struct packed {
        logic fmt, inv, dlb, tp, tn, lp, ln, lcv;
        logic [1:0] stb;
        logic ep, en;
    } vec_t;

    // receive-path vectors, run in order from reset (outputs start 0,0)
    localparam vec_t VEC [0:10] = '{
        '{1,0,0,0,0,1,0,0,2'd2,1,0},  // R6 normal update on rclk fall
        '{1,0,0,0,0,0,1,0,2'd1,1,0},  // R6 rclk rise ignored
        '{1,0,0,0,0,0,1,0,2'd2,0,1},  // R6
        '{1,1,0,0,0,1,0,0,2'd2,0,1},  // R7 inverted ignores rclk fall
        '{1,1,0,0,0,0,0,0,2'd1,1,1},  // R7 inverted, active-low on rise
        '{0,1,0,0,0,1,0,0,2'd2,1,0},  // R7 single-rail ignores inversion
        '{0,0,0,0,0,0,1,1,2'd2,1,1},  // R10 mark on either rail, lcv on rneg
        '{0,0,0,0,0,0,0,0,2'd2,0,0},  // R10
        '{1,0,1,1,0,0,1,0,2'd2,0,0},  // R12 loopback ignores line strobe
        '{1,0,1,1,0,0,0,0,2'd0,1,0},  // R12 system data on tclk fall
        '{1,1,1,0,1,0,0,0,2'd0,0,1}   // R12 R7 active-low loop
    };

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [1:0] s);
        tclk_fall = (s == 2'd0);
        rclk_rise = (s == 2'd1);
        rclk_fall = (s == 2'd2);
        mclk_tick = (s == 2'd3);
        @(posedge clk);
        @(negedge clk);
        tclk_fall = 0; rclk_rise = 0; rclk_fall = 0; mclk_tick = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R13 reset state
        chk("R13 line", {ttip, tring}, 2'b00);
        chk("R13 rx", {rpos, rneg}, 2'b00);

        for (int i = 0; i < 11; i++) begin
            fmt_sel = VEC[i].fmt; inv_sel = VEC[i].inv; dlb_en = VEC[i].dlb;
            tpos = VEC[i].tp; tneg = VEC[i].tn;
            rline_pos = VEC[i].lp; rline_neg = VEC[i].ln; lcv = VEC[i].lcv;
            pulse(VEC[i].stb);
            chk($sformatf("R6/R7/R10/R12 vector %0d", i), {rpos, rneg}, {VEC[i].ep, VEC[i].en});
        end
        dlb_en = 0; inv_sel = 0; fmt_sel = 1;

        // R1 all ones to line, first mark positive after reset (R13)
        taos = 1;
        pulse(2'd3); chk("R1 mark 1", {ttip, tring}, 2'b10);
        pulse(2'd3); chk("R1 mark 2", {ttip, tring}, 2'b01);
        pulse(2'd3); chk("R1 mark 3", {ttip, tring}, 2'b10);
        tpos = 1; tneg = 1;
        pulse(2'd0); chk("R1 tclk ignored", {ttip, tring}, 2'b10);

        // R2 all ones together with remote loopback
        rlb_en = 1; rline_pos = 0; rline_neg = 0;
        pulse(2'd1); chk("R2 loop strobe blocked", {ttip, tring}, 2'b10);
        pulse(2'd3); chk("R2 ones continue", {ttip, tring}, 2'b01);

        // R11 remote loopback
        taos = 0; rline_pos = 1; rline_neg = 1;
        pulse(2'd1); chk("R11 loop copy", {ttip, tring}, 2'b11);
        tpos = 0; tneg = 0;
        pulse(2'd0); chk("R11 tclk ignored", {ttip, tring}, 2'b11);
        rline_pos = 1; rline_neg = 0;
        pulse(2'd1); chk("R11 loop copy 2", {ttip, tring}, 2'b10);

        // R10 single-rail AMI coding, tneg not data
        rlb_en = 0; fmt_sel = 0;
        tpos = 1; tneg = 0; pulse(2'd0); chk("R10 ami 1", {ttip, tring}, 2'b10);
        tpos = 0; tneg = 1; pulse(2'd0); chk("R10 tneg not data", {ttip, tring}, 2'b00);
        tpos = 1; tneg = 1; pulse(2'd0); chk("R10 ami 2", {ttip, tring}, 2'b01);
        tpos = 1; tneg = 0; pulse(2'd0); chk("R10 ami 3", {ttip, tring}, 2'b10);

        // R8 format select, R7 transmit polarity
        fmt_sel = 1; tpos = 1; tneg = 1;
        pulse(2'd0); chk("R8 dual rails", {ttip, tring}, 2'b11);
        inv_sel = 1; tpos = 0; tneg = 1;
        pulse(2'd0); chk("R7 active-low tx", {ttip, tring}, 2'b10);
        inv_sel = 0; fmt_sel = 0; tpos = 1; tneg = 1;
        pulse(2'd0); chk("R8 single coded", {ttip, tring}, 2'b01);

        // R3 R4 all ones to receive outputs with digital loopback
        fmt_sel = 1; raos = 1; dlb_en = 1; lcv = 1; tpos = 1; tneg = 0;
        pulse(2'd0); chk("R4 loop strobe blocked", {rpos, rneg}, 2'b01);
        pulse(2'd3); chk("R3 dual mark 1", {rpos, rneg}, 2'b10);
        pulse(2'd3); chk("R3 dual mark 2", {rpos, rneg}, 2'b01);
        fmt_sel = 0;
        pulse(2'd3); chk("R3 single ones", {rpos, rneg}, 2'b11);
        fmt_sel = 1; inv_sel = 1;
        pulse(2'd3); chk("R3 R7 inverted ones", {rpos, rneg}, 2'b01);
        raos = 0; dlb_en = 0; inv_sel = 0;

        // R5 alarm test forcing, data unaffected
        atm_n = 0; lcv = 0; clk_loss = 1; rlos = 1;
        #1;
        chk("R5 forced alarms", {lcv_o, clk_loss_o}, 2'b10);
        chk("R5 forced rlos", {rlos_o, 1'b0}, 2'b00);
        fmt_sel = 1; rline_pos = 1; rline_neg = 1;
        pulse(2'd2); chk("R5 data moves", {rpos, rneg}, 2'b11);
        fmt_sel = 0; rline_pos = 0; rline_neg = 0;
        pulse(2'd2); chk("R5 R10 forced lcv on rneg", {rpos, rneg}, 2'b01);
        atm_n = 1;
        #1;
        chk("R5 pass alarms", {lcv_o, clk_loss_o}, 2'b01);
        chk("R5 pass rlos", {rlos_o, 1'b0}, 2'b10);
        clk_loss = 0; rlos = 0;

        // R9 automatic format detection from reset (R13)
        tpos = 0; tneg = 0; fmt_sel = 1; ja_en = 1;
        do_reset();
        lcv = 0; rline_pos = 0; rline_neg = 1;
        pulse(2'd2); chk("R9 R13 single after reset", {rpos, rneg}, 2'b10);
        tneg = 1; pulse(2'd0); tneg = 0;
        pulse(2'd2); chk("R9 dual on activity", {rpos, rneg}, 2'b01);
        for (int k = 0; k < 31; k++) pulse(2'd0);
        rline_pos = 1; rline_neg = 0;
        pulse(2'd2); chk("R9 dual after 31 idle", {rpos, rneg}, 2'b10);
        pulse(2'd0);
        rline_pos = 0; rline_neg = 1;
        pulse(2'd2); chk("R9 single after 32 idle", {rpos, rneg}, 2'b10);
        rline_pos = 1; rline_neg = 0;
        pulse(2'd2); chk("R9 single lcv on rneg", {rpos, rneg}, 2'b10);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule